// File: doc/BRIEF.md
# Keyed Register Write Guard

This block protects a peripheral's register file against stray writes. It sits behind a simple single-cycle memory-mapped slave port and qualifies every write aimed at a protected register. Such a write takes effect only while two 32-bit key registers both hold their own fixed magic constants. The key registers themselves are always writable, so software opens the gate by writing both magic values. It closes the gate again by writing zero, or any other value, to either key.

A protected write that arrives while the gate is closed is dropped without a trace. The bus transfer still completes in its normal single cycle, and nothing signals an error. The gate's decision comes out as a single write-enable qualifier, `protWrEn`, together with the current gate state. A small test register file of `NREG` words stands in for the protected registers. One unprotected scratch word shows that the decode separates protected from unprotected space.

Top module: `key_write_guard`

## Requirements
- R1: After reset both keys read as 0, `unlocked` is 0, and every protected register and the scratch word read as 0.
- R2: The key registers sit at byte offsets 0x6C (first key) and 0x70 (second key). Each accepts any 32-bit write in any gate state and reads back the value written.
- R3: `unlocked` is 1 exactly when the first key holds 0x83E70B13 and the second key holds 0x95A4F1E0. It changes only in the cycle after a key write.
- R4: With only one of the two keys holding its magic value, the gate stays locked.
- R5: A write to a protected register (word-aligned offsets 0x00 up to NREG*4-1) while locked leaves `protWrEn` at 0 and leaves the register unchanged.
- R6: A protected write while unlocked raises `protWrEn` in that same cycle, and the register holds the new data from the next cycle on.
- R7: Writing 0, or any value other than its magic constant, to either key locks the gate from the next cycle on.
- R8: The scratch word at offset 0x7C accepts writes whether the gate is locked or not.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Transfer strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| unlocked | output | 1 | Gate open: both keys hold their magic values |
| protWrEn | output | 1 | Qualified write enable for the protected register file |

## Verification
The checker watches, on every cycle, that `protWrEn` never rises without a write and never rises while locked. It also checks that a locked protected write is suppressed, that the gate state moves only after a key write, and that a zero key write always leaves the gate locked. The bench scenarios show what a property cannot see from the ports alone. These are the exact magic values, the behaviour with one key correct, the relock on a near-miss value, read-back of the keys and of the scratch word, and whether a protected register really kept or took the data.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;

  localparam logic [31:0] KEY0_MAGIC = 32'h83E7_0B13;
  localparam logic [31:0] KEY1_MAGIC = 32'h95A4_F1E0;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrKey0;
    logic wrKey1;
    logic wrScratch;
    logic wrProt;
  } guardStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_KEY0,
    RD_KEY1,
    RD_SCRATCH,
    RD_PROT
  } rdSel_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import key_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 'h7C,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              unlocked,
  output guardStrobe_t      strb,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  regIdx,
  output logic              protWrEn
);

  localparam int PROT_BYTES = NREG * 4;

  logic isKey0, isKey1, isScratch, isProt, wrCycle;

  always_comb begin
    isKey0    = (busAddr == KEY0_ADDR);
    isKey1    = (busAddr == KEY1_ADDR);
    isScratch = (busAddr == SCRATCH_ADDR);
    isProt    = (busAddr[1:0] == 2'b00) && (int'(busAddr) < PROT_BYTES);
    wrCycle   = busValid && busWrite;
    regIdx    = busAddr[IDX_W+1:2];
  end

  always_comb begin
    strb.wrKey0    = wrCycle && isKey0;
    strb.wrKey1    = wrCycle && isKey1;
    strb.wrScratch = wrCycle && isScratch;
    strb.wrProt    = wrCycle && isProt && unlocked;
    protWrEn       = strb.wrProt;
  end

  always_comb begin
    if (isKey0)         rdSel = RD_KEY0;
    else if (isKey1)    rdSel = RD_KEY1;
    else if (isScratch) rdSel = RD_SCRATCH;
    else if (isProt)    rdSel = RD_PROT;
    else                rdSel = RD_NONE;
  end

endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import key_guard_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  guardStrobe_t     strb,
  input  rdSel_t           rdSel,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [31:0]      busWdata,
  output logic             unlocked,
  output logic [31:0]      busRdata
);

  logic [31:0] key0, key1, scratch;
  logic [31:0] regFile [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      key0    <= '0;
      key1    <= '0;
      scratch <= '0;
    end else begin
      if (strb.wrKey0)    key0    <= busWdata;
      if (strb.wrKey1)    key1    <= busWdata;
      if (strb.wrScratch) scratch <= busWdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (strb.wrProt && (int'(regIdx) == g))
        regFile[g] <= busWdata;
    end
  end

  // Gate state follows the stored keys directly
  assign unlocked = (key0 == KEY0_MAGIC) && (key1 == KEY1_MAGIC);

  always_comb begin
    case (rdSel)
      RD_KEY0:    busRdata = key0;
      RD_KEY1:    busRdata = key1;
      RD_SCRATCH: busRdata = scratch;
      RD_PROT:    busRdata = regFile[regIdx];
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/key_write_guard.sv
module key_write_guard
  import key_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 'h7C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              unlocked,
  output logic              protWrEn
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  guardStrobe_t     strb;
  rdSel_t           rdSel;
  logic [IDX_W-1:0] regIdx;

  guard_ctrl #(
    .ADDR_W(ADDR_W), .NREG(NREG), .KEY0_ADDR(KEY0_ADDR),
    .KEY1_ADDR(KEY1_ADDR), .SCRATCH_ADDR(SCRATCH_ADDR)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .unlocked(unlocked), .strb(strb), .rdSel(rdSel), .regIdx(regIdx),
    .protWrEn(protWrEn)
  );

  guard_datapath #(.NREG(NREG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .regIdx(regIdx),
    .busWdata(busWdata), .unlocked(unlocked), .busRdata(busRdata)
  );

endmodule

// File: rtl/key_guard_chk.sv
module key_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int NREG = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              unlocked,
  input logic              protWrEn
);

  logic keyWr, protAddr;
  assign keyWr    = busValid && busWrite && (busAddr == KEY0_ADDR || busAddr == KEY1_ADDR);
  assign protAddr = (busAddr[1:0] == 2'b00) && (int'(busAddr) < NREG * 4);

  // R5
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && protAddr && !unlocked) |-> !protWrEn);

  // R6
  wren_needs_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> (unlocked && busValid && busWrite));

  // R3
  state_moves_on_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(unlocked) |-> $past(keyWr));

  // R7
  zero_key_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && busWdata == 32'h0) |=> !unlocked);

endmodule

bind key_write_guard key_guard_chk #(
  .ADDR_W(ADDR_W), .NREG(NREG), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .unlocked(unlocked), .protWrEn(protWrEn)
);

// File: tb/key_write_guard_bench.sv
module key_write_guard_bench;

  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        unlocked, protWrEn;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  // model state
  logic [31:0] mKey0 = '0, mKey1 = '0, mScratch = '0;
  logic [31:0] mRegs [NREG];

  always #4 clk = ~clk;

  key_write_guard u_key_write_guard (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .unlocked(unlocked), .protWrEn(protWrEn)
  );

  function automatic bit modelOpen();
    return (mKey0 == 32'h83E7_0B13) && (mKey1 == 32'h95A4_F1E0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write; returns protWrEn sampled mid-cycle
  task automatic doWrite(input logic [7:0] a, input logic [31:0] d, output logic en);
    @(posedge clk); #1;
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); en = protWrEn;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
    if (a == 8'h6C) mKey0 = d;
    else if (a == 8'h70) mKey1 = d;
    else if (a == 8'h7C) mScratch = d;
  endtask

  task automatic protWrite(input int idx, input logic [31:0] d, input string tag);
    logic en;
    bit open;
    open = modelOpen();
    doWrite(8'(idx * 4), d, en);
    check(tag, {31'b0, en}, {31'b0, open});
    if (open) mRegs[idx] = d;
  endtask

  task automatic keyWrite(input logic [7:0] a, input logic [31:0] d);
    logic en;
    doWrite(a, d, en);
  endtask

  // driver: pushes expected value, monitor compares
  task automatic doRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    busValid = 1; busWrite = 0; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    busValid = 0;
  endtask

  always @(negedge clk) begin
    if (busValid && !busWrite && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, busRdata, e);
    end
  end

  task automatic checkGate(input string tag);
    @(negedge clk);
    check(tag, {31'b0, unlocked}, {31'b0, modelOpen()});
  endtask

  task automatic readAllProt(input string tag);
    for (int i = 0; i < NREG; i++) doRead(8'(i * 4), mRegs[i], tag);
  endtask

  initial begin
    logic en;
    for (int i = 0; i < NREG; i++) mRegs[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    checkGate("R1 gate after reset");
    doRead(8'h6C, 32'h0, "R1 key0 reset");
    doRead(8'h70, 32'h0, "R1 key1 reset");
    doRead(8'h7C, 32'h0, "R1 scratch reset");
    readAllProt("R1 prot reset");

    // R5 locked protected write dropped
    protWrite(2, 32'hAAAA_5555, "R5 wren while locked");
    doRead(8'h08, mRegs[2], "R5 reg kept");

    // R8 scratch always writable
    doWrite(8'h7C, 32'h0000_1234, en);
    doRead(8'h7C, 32'h0000_1234, "R8 scratch locked write");

    // R4 one key correct
    keyWrite(8'h6C, 32'h83E7_0B13);
    checkGate("R4 only key0");
    doRead(8'h6C, 32'h83E7_0B13, "R2 key0 readback");
    protWrite(3, 32'h1111_2222, "R4 wren with one key");
    doRead(8'h0C, 32'h0, "R4 reg kept");
    keyWrite(8'h6C, 32'h0);
    keyWrite(8'h70, 32'h95A4_F1E0);
    checkGate("R4 only key1");

    // R3 both keys
    keyWrite(8'h6C, 32'h83E7_0B13);
    checkGate("R3 both keys open");
    doRead(8'h70, 32'h95A4_F1E0, "R2 key1 readback");

    // R6 unlocked writes
    protWrite(2, 32'hDEAD_BEEF, "R6 wren while open");
    protWrite(7, 32'h0BAD_F00D, "R6 wren last reg");
    protWrite(0, 32'h0000_0001, "R6 wren first reg");
    readAllProt("R6 reg updated");

    // R7 near-miss value relocks
    keyWrite(8'h70, 32'h95A4_F1E1);
    checkGate("R7 near-miss relock");
    protWrite(2, 32'h5555_5555, "R7 wren after relock");
    doRead(8'h08, 32'hDEAD_BEEF, "R7 reg kept");
    doRead(8'h70, 32'h95A4_F1E1, "R2 key1 any value");

    // R7 zero relock
    keyWrite(8'h70, 32'h95A4_F1E0);
    checkGate("R3 reopen");
    doWrite(8'h7C, 32'hCAFE_0000, en);
    doRead(8'h7C, 32'hCAFE_0000, "R8 scratch open write");
    keyWrite(8'h6C, 32'h0);
    keyWrite(8'h70, 32'h0);
    checkGate("R7 zero relock");
    protWrite(7, 32'h7777_7777, "R7 wren after zero");

    // R9 unmapped
    doRead(8'h60, 32'h0, "R9 unmapped read");
    doRead(8'h0A, 32'h0, "R9 unaligned read");
    keyWrite(8'h6C, 32'h83E7_0B13);
    keyWrite(8'h70, 32'h95A4_F1E0);
    doWrite(8'h60, 32'hFFFF_FFFF, en);
    check("R9 unmapped wren", {31'b0, en}, 32'h0);
    readAllProt("R9 regs unchanged");
    doRead(8'h7C, 32'hCAFE_0000, "R9 scratch unchanged");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule